// File: doc/BRIEF.md
# Multi-channel FIFO interrupt aggregator

This block collects the FIFO event conditions of a bank of audio stream channels and merges them into a single level-sensitive host interrupt. Every channel index carries six event types that cover both a capture FIFO and a playback FIFO: almost-empty, almost-full and overflow for each direction. Each event arrives as a one-cycle pulse. The block latches the pulse into a sticky raw status bit, and the bit stays set until software clears it.

Software sees the state through a small word-addressed register file. Four channels share one 32-bit word, and each channel occupies an 8-bit lane. There are separate word groups for the event enables, the write-one-to-clear strobes, the raw status and the enabled (masked) status. A further word holds one host-mask bit per channel. That bit decides whether the channel's enabled events can reach the interrupt line.

Writes go through a write port. Reads use a separate combinational read port, so a read returns the current register value in the same cycle as its address.

Top module: `fifo_irq_aggregator`

## Requirements
- R1: After reset all enables, raw bits and host-mask bits are 0, every address reads 0 and `irq_o` is low.
- R2: With NUM_WORDS = 3 the addresses are laid out as follows:
  - enable words at 0..2;
  - clear words at 3..5;
  - raw words at 6..8;
  - masked words at 9..11;
  - the host-mask word at 12.
  Addresses 13..15 read 0, and writes to them change nothing.
- R3: Event `t` of channel `c` sits in word `c/4` of each group, at bit `8*(c mod 4)+t`. The type codes are:
  - 0: capture almost-empty;
  - 1: capture almost-full;
  - 2: playback almost-empty;
  - 3: playback almost-full;
  - 4: capture overflow;
  - 5: playback overflow.
  The event input bit for channel `c`, type `t`, is `evt_i[6*c+t]`.
- R4: An event pulse sets its raw bit, which reads 1 from the cycle after the pulse and stays 1 for as long as no clear reaches it.
- R5: Writing a clear word removes every raw bit whose written bit is 1, from the next cycle, and leaves bits written 0 unchanged. Clear words read as 0.
- R6: When an event pulse and a clear of the same bit fall in the same cycle, the raw bit ends up set.
- R7: Enable words can be written and read back. Lane bits 6 and 7, and lanes of channels 10 and 11, always read 0. A masked word equals the raw word AND the enable word.
- R8: Host-mask bit `c` of the host-mask word (bits 9..0) admits channel `c`. `irq_o` is high exactly when some channel with its host-mask bit set has a bit set in its masked status.
- R9: Writes to the raw and masked words change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 60 | Event pulses, bit 6*channel+type |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 4 | Write word address |
| wdata | input | 32 | Write data |
| raddr | input | 4 | Read word address |
| rdata | output | 32 | Read data for raddr, combinational |
| irq_o | output | 1 | Shared level interrupt |

## Verification
The case that needs care is an event pulse landing in the same cycle as a clear write to the same raw bit. The bench provokes it by driving the pulse and the clear-word write before the same clock edge. It then reads the raw word back and expects the bit still set, because the set must win. The same stimulus is also applied with the clear aimed at a neighbouring bit, which must drop while the pulsed bit rises. All expected words are rebuilt in the bench from the lane formula over every address after each step.

// File: rtl/fia_pkg.sv
package fia_pkg;
   localparam int EVT_TYPES   = 6;
   localparam int LANE_W      = 8;
   localparam int LANES_PER_W = 4;
   localparam int WORD_W      = LANE_W * LANES_PER_W;

   typedef enum logic [2:0] {
      EV_CAP_AE  = 3'd0,
      EV_CAP_AF  = 3'd1,
      EV_PLY_AE  = 3'd2,
      EV_PLY_AF  = 3'd3,
      EV_CAP_OVF = 3'd4,
      EV_PLY_OVF = 3'd5
   } evt_code_e;

   typedef enum logic [2:0] {
      GRP_EN    = 3'd0,
      GRP_CLR   = 3'd1,
      GRP_RAW   = 3'd2,
      GRP_MSK   = 3'd3,
      GRP_HMASK = 3'd4,
      GRP_NONE  = 3'd5
   } grp_e;
endpackage

// File: rtl/fia_addr_decode.sv
module fia_addr_decode
   import fia_pkg::*;
#(
   parameter int NUM_WORDS = 3,
   parameter int ADDR_W    = 4,
   parameter int WIDX_W    = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output grp_e              grp,
   output logic [WIDX_W-1:0] widx
);
   always_comb begin
      int a;
      a    = int'(addr);
      grp  = GRP_NONE;
      widx = '0;
      if (a < NUM_WORDS) begin
         grp  = GRP_EN;
         widx = WIDX_W'(a);
      end else if (a < 2*NUM_WORDS) begin
         grp  = GRP_CLR;
         widx = WIDX_W'(a - NUM_WORDS);
      end else if (a < 3*NUM_WORDS) begin
         grp  = GRP_RAW;
         widx = WIDX_W'(a - 2*NUM_WORDS);
      end else if (a < 4*NUM_WORDS) begin
         grp  = GRP_MSK;
         widx = WIDX_W'(a - 3*NUM_WORDS);
      end else if (a == 4*NUM_WORDS) begin
         grp  = GRP_HMASK;
      end
   end
endmodule

// File: rtl/fia_chan_lane.sv
module fia_chan_lane
   import fia_pkg::*;
#(
   parameter int NTYPE = EVT_TYPES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTYPE-1:0] evt_i,
   input  logic             en_we,
   input  logic [NTYPE-1:0] en_wdata,
   input  logic [NTYPE-1:0] clr_i,
   output logic [NTYPE-1:0] raw_o,
   output logic [NTYPE-1:0] en_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_o <= '0;
         en_o  <= '0;
      end else begin
         raw_o <= (raw_o & ~clr_i) | evt_i;
         if (en_we) en_o <= en_wdata;
      end
   end

   // R4
   raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt_i) & ~raw_o) == '0));
   // R4
   raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(raw_o) & ~$past(clr_i) & ~raw_o) == '0));
   // R5
   raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr_i) & ~$past(evt_i) & raw_o) == '0));
   // R7
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we |=> $stable(en_o));
endmodule

// File: rtl/fia_word_pack.sv
module fia_word_pack
   import fia_pkg::*;
#(
   parameter int NUM_CH    = 10,
   parameter int NUM_WORDS = 3
) (
   input  logic [NUM_CH*EVT_TYPES-1:0]  bits_i,
   output logic [NUM_WORDS*WORD_W-1:0] words_o
);
   localparam int PAD_W = LANE_W - EVT_TYPES;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      for (genvar l = 0; l < LANES_PER_W; l++) begin : g_lane
         localparam int CH = w*LANES_PER_W + l;
         if (CH < NUM_CH) begin : g_used
            assign words_o[w*WORD_W + l*LANE_W +: LANE_W] =
               {{PAD_W{1'b0}}, bits_i[CH*EVT_TYPES +: EVT_TYPES]};
         end else begin : g_empty
            assign words_o[w*WORD_W + l*LANE_W +: LANE_W] = '0;
         end
      end
   end
endmodule

// File: rtl/fifo_irq_aggregator.sv
module fifo_irq_aggregator
   import fia_pkg::*;
#(
   parameter int NUM_CH = 10,
   parameter int ADDR_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CH*EVT_TYPES-1:0] evt_i,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           waddr,
   input  logic [WORD_W-1:0]           wdata,
   input  logic [ADDR_W-1:0]           raddr,
   output logic [WORD_W-1:0]           rdata,
   output logic                        irq_o
);
   localparam int NUM_WORDS = (NUM_CH + LANES_PER_W - 1) / LANES_PER_W;
   localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int NBITS     = NUM_CH * EVT_TYPES;

   if (NUM_CH < 1 || NUM_CH > WORD_W) begin : g_bad_ch
      $error("NUM_CH must lie in 1..32");
   end
   if (4*NUM_WORDS + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register groups");
   end

   grp_e              wgrp, rgrp;
   logic [WIDX_W-1:0] widx, rwidx;

   fia_addr_decode #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .WIDX_W(WIDX_W))
      u_wdec (.addr(waddr), .grp(wgrp), .widx(widx));
   fia_addr_decode #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .WIDX_W(WIDX_W))
      u_rdec (.addr(raddr), .grp(rgrp), .widx(rwidx));

   logic [NBITS-1:0]  raw_all, en_all, msk_all;
   logic [NUM_CH-1:0] hmask, ch_hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int W = c / LANES_PER_W;
      localparam int L = c % LANES_PER_W;
      logic                 sel;
      logic [EVT_TYPES-1:0] lane_d, clr;

      assign sel    = wr_en && (widx == WIDX_W'(W));
      assign lane_d = wdata[L*LANE_W +: EVT_TYPES];
      assign clr    = (sel && wgrp == GRP_CLR) ? lane_d : '0;

      fia_chan_lane #(.NTYPE(EVT_TYPES)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt_i   (evt_i[c*EVT_TYPES +: EVT_TYPES]),
         .en_we   (sel && wgrp == GRP_EN),
         .en_wdata(lane_d),
         .clr_i   (clr),
         .raw_o   (raw_all[c*EVT_TYPES +: EVT_TYPES]),
         .en_o    (en_all[c*EVT_TYPES +: EVT_TYPES])
      );

      assign msk_all[c*EVT_TYPES +: EVT_TYPES] =
         raw_all[c*EVT_TYPES +: EVT_TYPES] & en_all[c*EVT_TYPES +: EVT_TYPES];
      assign ch_hit[c] = hmask[c] && (|msk_all[c*EVT_TYPES +: EVT_TYPES]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hmask <= '0;
      else if (wr_en && wgrp == GRP_HMASK) hmask <= wdata[NUM_CH-1:0];
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata;

   assign irq_o = |ch_hit;

   logic [NUM_WORDS*WORD_W-1:0] en_words, raw_words, msk_words;

   fia_word_pack #(.NUM_CH(NUM_CH), .NUM_WORDS(NUM_WORDS))
      u_pack_en  (.bits_i(en_all),  .words_o(en_words));
   fia_word_pack #(.NUM_CH(NUM_CH), .NUM_WORDS(NUM_WORDS))
      u_pack_raw (.bits_i(raw_all), .words_o(raw_words));
   fia_word_pack #(.NUM_CH(NUM_CH), .NUM_WORDS(NUM_WORDS))
      u_pack_msk (.bits_i(msk_all), .words_o(msk_words));

   always_comb begin
      rdata = '0;
      unique case (rgrp)
         GRP_EN:    rdata = en_words[rwidx*WORD_W +: WORD_W];
         GRP_RAW:   rdata = raw_words[rwidx*WORD_W +: WORD_W];
         GRP_MSK:   rdata = msk_words[rwidx*WORD_W +: WORD_W];
         GRP_HMASK: rdata = WORD_W'(hmask);
         default:   rdata = '0;
      endcase
   end

   // R8
   irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (hmask != '0));
   // R8
   irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_all == '0) |-> !irq_o);
   // R9
   status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wgrp == GRP_RAW || wgrp == GRP_MSK) && evt_i == '0)
         |=> $stable(raw_all) && $stable(en_all) && $stable(hmask));
   // R7
   masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_all & ~raw_all) == '0);
endmodule

// File: tb/sim_fifo_irq_aggregator.sv
module sim_fifo_irq_aggregator;
   localparam int NCH = 10;
   localparam int NT  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [59:0]   evt_i = '0;
   logic          wr_en = 1'b0;
   logic [3:0]    waddr = '0;
   logic [31:0]   wdata = '0;
   logic [3:0]    raddr = '0;
   logic [31:0]   rdata;
   logic          irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [5:0] m_raw [NCH];
   logic [5:0] m_en  [NCH];
   logic [9:0] m_hm;

   always #2.5 clk = ~clk;

   fifo_irq_aggregator u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
      .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // group: 0 enable, 1 raw, 2 masked
   function automatic logic [31:0] exp_word(input int grp, input int w);
      logic [31:0] r;
      r = '0;
      for (int l = 0; l < 4; l++) begin
         int ch;
         ch = 4*w + l;
         if (ch < NCH) begin
            for (int t = 0; t < NT; t++) begin
               logic b;
               b = (grp == 0) ? m_en[ch][t] :
                   (grp == 1) ? m_raw[ch][t] : (m_raw[ch][t] & m_en[ch][t]);
               r[8*l + t] = b;
            end
         end
      end
      return r;
   endfunction

   function automatic logic exp_irq();
      logic r;
      r = 1'b0;
      for (int c = 0; c < NCH; c++)
         if (m_hm[c] && (m_raw[c] & m_en[c]) != 6'd0) r = 1'b1;
      return r;
   endfunction

   task automatic rd(input int a, output logic [31:0] v);
      raddr = 4'(a);
      #0.5;
      v = rdata;
   endtask

   // one clock with the given stimulus; the model follows the requirements
   task automatic cyc(input logic [59:0] e, input logic we, input int a, input logic [31:0] d);
      @(negedge clk);
      evt_i = e; wr_en = we; waddr = 4'(a); wdata = d;
      @(negedge clk);
      evt_i = '0; wr_en = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         logic [5:0] clr;
         clr = '0;
         if (we && a == 3 + c/4) clr = d[8*(c%4) +: 6];       // R5
         if (we && a == c/4) m_en[c] = d[8*(c%4) +: 6];        // R7
         m_raw[c] = (m_raw[c] & ~clr) | e[6*c +: 6];           // R4 R6
      end
      if (we && a == 12) m_hm = d[9:0];                        // R8
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      for (int a = 0; a < 16; a++) begin
         rd(a, v);
         if (a < 3)       chk({tag, " R7 enable word"}, v, exp_word(0, a));
         else if (a < 6)  chk({tag, " R5 clear word reads 0"}, v, 32'h0);
         else if (a < 9)  chk({tag, " R4 raw word"}, v, exp_word(1, a-6));
         else if (a < 12) chk({tag, " R7 masked word"}, v, exp_word(2, a-9));
         else if (a == 12) chk({tag, " R8 host mask"}, v, {22'h0, m_hm});
         else             chk({tag, " R2 unused address"}, v, 32'h0);
      end
      chk({tag, " R8 irq"}, {31'h0, irq_o}, {31'h0, exp_irq()});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int c = 0; c < NCH; c++) begin m_raw[c] = '0; m_en[c] = '0; end
      m_hm = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1 reset");

      // R3 R4 R5: every channel and type, enables off
      for (int c = 0; c < NCH; c++) begin
         for (int t = 0; t < NT; t++) begin
            logic [59:0] e;
            e = '0; e[6*c+t] = 1'b1;
            cyc(e, 1'b0, 0, 0);
            rd(6 + c/4, v);
            chk("R3 bit position", v, 32'h1 << (8*(c%4) + t));
            repeat (2) @(negedge clk);
            rd(6 + c/4, v);
            chk("R4 sticky raw", v, 32'h1 << (8*(c%4) + t));
            check_all("R3 sweep set");
            cyc('0, 1'b1, 3 + c/4, 32'h1 << (8*(c%4) + t));
            check_all("R5 sweep clear");
         end
      end

      // R7: enable everything, padding must read 0
      for (int w = 0; w < 3; w++) cyc('0, 1'b1, w, 32'hFFFF_FFFF);
      rd(0, v); chk("R7 enable padding", v, 32'h3F3F_3F3F);
      rd(2, v); chk("R7 enable absent lanes", v, 32'h0000_3F3F);
      cyc('0, 1'b1, 12, 32'hFFFF_FFFF);
      check_all("R8 mask all");

      // R8: one channel at a time against a sweeping host mask
      for (int c = 0; c < NCH; c++) begin
         logic [59:0] e;
         e = '0; e[6*c + (c % NT)] = 1'b1;
         cyc(e, 1'b1, 12, 32'h0);
         check_all("R8 channel pending, mask off");
         for (int h = 0; h < NCH; h++) begin
            cyc('0, 1'b1, 12, 32'h1 << h);
            chk("R8 irq per mask bit", {31'h0, irq_o}, {31'h0, (h == c)});
         end
         cyc('0, 1'b1, 0 + c/4, 32'h0);
         check_all("R7 enable off hides event");
         cyc('0, 1'b1, c/4, 32'hFFFF_FFFF);
         cyc('0, 1'b1, 3 + c/4, 32'hFFFF_FFFF);
         check_all("R5 full clear");
      end

      // R5: writing zeros to a clear word leaves pending bits
      cyc(60'h0F0_F0F0_F0F0_F0F0, 1'b0, 0, 0);
      cyc('0, 1'b1, 4, 32'h0);
      check_all("R5 zero clear");

      // R9: writes to raw and masked words are ignored
      cyc('0, 1'b1, 7, 32'h0);
      cyc('0, 1'b1, 10, 32'hFFFF_FFFF);
      cyc('0, 1'b1, 14, 32'hFFFF_FFFF);
      check_all("R9 status write ignored");

      // R6: set and clear of the same bit in one cycle
      for (int c = 0; c < NCH; c++) begin
         logic [59:0] e;
         cyc('0, 1'b1, 3 + c/4, 32'hFFFF_FFFF);
         e = '0; e[6*c + 2] = 1'b1;
         cyc(e, 1'b1, 3 + c/4, 32'h3F << (8*(c%4)));
         rd(6 + c/4, v);
         chk("R6 set wins", v & (32'h3F << (8*(c%4))), 32'h4 << (8*(c%4)));
         e = '0; e[6*c + 5] = 1'b1;
         cyc(e, 1'b1, 3 + c/4, 32'h4 << (8*(c%4)));
         check_all("R6 neighbour clear");
      end

      // R1: reset in the middle of activity
      @(negedge clk); rst_n = 1'b0;
      for (int c = 0; c < NCH; c++) begin m_raw[c] = '0; m_en[c] = '0; end
      m_hm = '0;
      @(negedge clk); rst_n = 1'b1;
      check_all("R1 second reset");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule